// File: doc/BRIEF.md
# Interrupt Redirection Table Register Window

This block is the software-facing register front end of an I/O interrupt controller. Software cannot address the redirection table directly. It first writes an 8-bit selector through a select register, and then reads or writes 32 bits at a time through a data window. Each selector value at 0x10 or above picks one half of a 64-bit redirection entry. The low selector values pick an identification register and a version register.

The block claims only bus accesses that fall inside its 256-byte address region. It answers each claimed read one cycle later with 32-bit data. It takes write lengths of 1, 2, 4 or 8 bytes and drops any other length. Whenever a table entry is written, it raises side-band strobes for the delivery logic, which lives elsewhere:
- a mask-change event that carries the entry index and the new mask value;
- a re-service request for a level-triggered pin that is still pending.

The delivery logic sets the read-only remote-IRR bit of an entry through a per-pin input. A write to the lower half of that entry clears the bit.

Top module: `irq_regwin`

## Requirements
- R1: `bus_claim` is high exactly when `bus_valid` is high and address bits above bit 7 equal those of the parameter `BASE`. Inside the region, only address bits 7:0 decode: offset 0x00 is the select register and offset 0x10 is the data window. A read of any other offset returns 0 and a write to it does nothing.
- R2: A write to the select register stores only data bits 7:0. A read at offset 0x00 returns the selector, zero-extended.
- R3: A selector S >= 0x10 addresses entry (S-0x10)>>1. An odd S maps the window to entry bits 63:32 and an even S maps it to bits 31:0.
- R4: When the computed entry index is >= `NPINS` (24), a window read returns 0xFFFFFFFF. A window write at that index changes no entry and raises no strobe.
- R5: An upper-half write replaces only bits 63:32. A lower-half write replaces only bits 31:0, and bit 14 (remote-IRR) always ends up 0 whatever the data carries.
- R6: A pulse on `rirr_set[i]` sets bit 14 of entry i. If that pulse falls in the same cycle as a lower-half write to entry i, the set wins.
- R7: A write of length 1, 2 or 4 uses data bits 7:0, 15:0 or 31:0 respectively, zero-extended. A write of length 8 uses bits 31:0. A write of any other length changes nothing and raises no strobe.
- R8: In the cycle after a table write, `mask_evt` is high if and only if the write changed bit 16 (mask). When it is high, `evt_index` holds the entry index and `mask_val` holds the new value of bit 16.
- R9: In the cycle after a table write, `resvc_req` is high if and only if the entry's bit 15 (trigger, 1 = level) is 1 after the write and `pend_i` for that entry was high in the write cycle. When it is high, `evt_index` holds the entry index.
- R10: Selector 0x00 reads the ID register, which holds bits 27:24 and reads 0 elsewhere. A window write while the selector is 0x00 loads those bits. Selector 0x01 reads version 0x00170011. Any other selector below 0x10 reads 0.
- R11: After reset the selector and the ID are 0. Every entry reads 0x0000000000010000 (mask set). `rd_valid`, `mask_evt` and `resvc_req` are low.
- R12: A claimed read raises `rd_valid` with `rd_data` in the next cycle. Writes and unclaimed reads leave `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (32) | Byte address |
| bus_len | input | 4 | Access length in bytes |
| bus_wdata | input | 32 | Write data |
| bus_claim | output | 1 | Access falls in this device's region |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pend_i | input | NPINS (24) | Per-pin pending flags from delivery logic |
| rirr_set | input | NPINS (24) | Per-pin remote-IRR set pulses |
| evt_index | output | IW (5) | Entry index of the last strobe |
| mask_evt | output | 1 | Mask bit of an entry changed |
| mask_val | output | 1 | New mask value |
| resvc_req | output | 1 | Re-service request for a pending level pin |

## Verification
Two events can land on the same entry in the same cycle: a lower-half window write and a remote-IRR set pulse. The write forces bit 14 low, while the pulse drives it high. The bench provokes the collision in a directed case and also lets it happen at random by pulsing `rirr_set` alongside random window writes. It then judges the outcome by reading the lower half back and expecting bit 14 set. Mask-change and re-service strobes raised by that same write are checked in the same step.

// File: rtl/irq_regwin_pkg.sv
// Package: shared field positions, constants and helpers for the register window.
// Assumes the redirection entry layout consumed by the delivery logic.
package irq_regwin_pkg;
    localparam int          RIRR_BIT   = 14;
    localparam int          TRIG_BIT   = 15;
    localparam int          MASK_BIT   = 16;
    localparam logic [7:0]  OFF_SEL    = 8'h00;
    localparam logic [7:0]  OFF_WIN    = 8'h10;
    localparam logic [7:0]  SEL_TABLE  = 8'h10;
    localparam logic [7:0]  VER_CODE   = 8'h11;
    localparam logic [63:0] ENTRY_RST  = 64'h0000_0000_0001_0000;

    // Returns the zero-extended data a write of the given byte length carries.
    function automatic logic [31:0] len_data(input logic [3:0] len, input logic [31:0] d);
        case (len)
            4'd1:       return {24'd0, d[7:0]};
            4'd2:       return {16'd0, d[15:0]};
            default:    return d;
        endcase
    endfunction

    // True when the byte length is one the block accepts.
    function automatic logic len_ok(input logic [3:0] len);
        return (len == 4'd1) || (len == 4'd2) || (len == 4'd4) || (len == 4'd8);
    endfunction
endpackage

// File: rtl/irw_bus_decode.sv
// Bus decode: claims accesses inside the 256-byte region at BASE and picks
// the register from the low 8 address bits. Purely combinational.
module irw_bus_decode
    import irq_regwin_pkg::*;
#(
    parameter int             AW   = 32,
    parameter logic [AW-1:0]  BASE = 32'hFEC0_0000
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    len,
    input  logic [31:0]   wdata,
    output logic          hit,
    output logic          at_sel,
    output logic          at_win,
    output logic          len_good,
    output logic [31:0]   wdata_x
);
    // Region match, register decode and write-data extension.
    always_comb begin
        hit      = valid && (addr[AW-1:8] == BASE[AW-1:8]);
        at_sel   = hit && (addr[7:0] == OFF_SEL);
        at_win   = hit && (addr[7:0] == OFF_WIN);
        len_good = len_ok(len);
        wdata_x  = len_data(len, wdata);
    end
endmodule

// File: rtl/irw_entry_table.sv
// Redirection entry storage: one 64-bit register per pin. Half writes,
// remote-IRR clear on lower writes, remote-IRR set from delivery (set wins).
// Assumes wr_idx < NPINS whenever wr_en is high.
module irw_entry_table
    import irq_regwin_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic [NPINS-1:0] rirr_set,
    output logic [63:0]      cur_entry
);
    logic [63:0] ent_w [NPINS];

    for (genvar i = 0; i < NPINS; i++) begin : g_ent
        logic [63:0] e_q;
        // Holds one entry; a delivery set of remote-IRR overrides a write clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q <= ENTRY_RST;
            end else begin
                if (wr_en && (32'(wr_idx) == i)) begin
                    if (wr_hi) begin
                        e_q[63:32] <= wr_data;
                    end else begin
                        e_q[31:0]     <= wr_data;
                        e_q[RIRR_BIT] <= 1'b0;
                    end
                end
                if (rirr_set[i]) e_q[RIRR_BIT] <= 1'b1;
            end
        end
        assign ent_w[i] = e_q;
    end

    // Presents the currently selected entry.
    always_comb cur_entry = ent_w[wr_idx];
endmodule

// File: rtl/irw_event_gen.sv
// Side-band strobe generator: one cycle after an entry write, flags a mask
// change and a re-service request for a pending level-triggered pin.
module irw_event_gen #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [IW-1:0] idx,
    input  logic          hi,
    input  logic          d_mask,
    input  logic          d_trig,
    input  logic          old_mask,
    input  logic          old_trig,
    input  logic          pend,
    output logic [IW-1:0] evt_index,
    output logic          mask_evt,
    output logic          mask_val,
    output logic          resvc_req
);
    logic new_mask, new_trig;

    // Entry fields as they stand after the write.
    always_comb begin
        new_mask = hi ? old_mask : d_mask;
        new_trig = hi ? old_trig : d_trig;
    end

    // Registers the strobes and the index they refer to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_index <= '0;
            mask_evt  <= 1'b0;
            mask_val  <= 1'b0;
            resvc_req <= 1'b0;
        end else begin
            mask_evt  <= fire && (new_mask != old_mask);
            resvc_req <= fire && new_trig && pend;
            if (fire) begin
                evt_index <= idx;
                mask_val  <= new_mask;
            end
        end
    end
endmodule

// File: rtl/irq_regwin.sv
// Top: select/window register front end of an I/O interrupt controller.
// Assumes 32-bit read data and a synchronous active-low reset.
module irq_regwin
    import irq_regwin_pkg::*;
#(
    parameter int             NPINS = 24,
    parameter int             AW    = 32,
    parameter logic [AW-1:0]  BASE  = 32'hFEC0_0000,
    localparam int            IW    = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [AW-1:0]    bus_addr,
    input  logic [3:0]       bus_len,
    input  logic [31:0]      bus_wdata,
    output logic             bus_claim,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    input  logic [NPINS-1:0] pend_i,
    input  logic [NPINS-1:0] rirr_set,
    output logic [IW-1:0]    evt_index,
    output logic             mask_evt,
    output logic             mask_val,
    output logic             resvc_req
);
    localparam logic [31:0] VERSION = {8'd0, 8'(NPINS - 1), 8'd0, VER_CODE};

    logic        hit, at_sel, at_win, len_good;
    logic [31:0] wdata_x;
    logic [7:0]  sel_q;
    logic [3:0]  id_q;
    logic [7:0]  raw_idx;
    logic        in_table, idx_ok;
    logic [IW-1:0] idx;
    logic        wr_fire, ent_wr;
    logic [63:0] cur_entry;
    logic [31:0] win_val;

    irw_bus_decode #(.AW(AW), .BASE(BASE)) dec_i (
        .valid(bus_valid), .addr(bus_addr), .len(bus_len), .wdata(bus_wdata),
        .hit(hit), .at_sel(at_sel), .at_win(at_win), .len_good(len_good),
        .wdata_x(wdata_x)
    );

    // Selector to entry index and half.
    always_comb begin
        in_table = sel_q >= SEL_TABLE;
        raw_idx  = 8'(sel_q - SEL_TABLE) >> 1;
        idx_ok   = in_table && (32'(raw_idx) < NPINS);
        idx      = IW'(raw_idx);
        wr_fire  = hit && bus_write && len_good;
        ent_wr   = wr_fire && at_win && idx_ok;
    end

    // Select and ID registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= '0;
        end else if (wr_fire) begin
            if (at_sel) sel_q <= wdata_x[7:0];
            else if (at_win && sel_q == 8'h00) id_q <= wdata_x[27:24];
        end
    end

    irw_entry_table #(.NPINS(NPINS)) tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(ent_wr), .wr_idx(idx),
        .wr_hi(sel_q[0]), .wr_data(wdata_x), .rirr_set(rirr_set),
        .cur_entry(cur_entry)
    );

    irw_event_gen #(.IW(IW)) evt_i (
        .clk(clk), .rst_n(rst_n), .fire(ent_wr), .idx(idx), .hi(sel_q[0]),
        .d_mask(wdata_x[MASK_BIT]), .d_trig(wdata_x[TRIG_BIT]),
        .old_mask(cur_entry[MASK_BIT]), .old_trig(cur_entry[TRIG_BIT]),
        .pend(pend_i[idx]), .evt_index(evt_index), .mask_evt(mask_evt),
        .mask_val(mask_val), .resvc_req(resvc_req)
    );

    // Data window contents for the current selector.
    always_comb begin
        if (idx_ok)               win_val = sel_q[0] ? cur_entry[63:32] : cur_entry[31:0];
        else if (in_table)        win_val = '1;
        else if (sel_q == 8'h00)  win_val = {4'd0, id_q, 24'd0};
        else if (sel_q == 8'h01)  win_val = VERSION;
        else                      win_val = '0;
    end

    assign bus_claim = hit;

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= hit && !bus_write;
            if (hit && !bus_write) begin
                if (at_sel)      rd_data <= {24'd0, sel_q};
                else if (at_win) rd_data <= win_val;
                else             rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/irq_regwin_chk.sv
// Checker: port-level timing properties of the register window, bound to the top.
module irq_regwin_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_valid,
    input logic bus_write,
    input logic bus_claim,
    input logic rd_valid,
    input logic mask_evt,
    input logic resvc_req
);
    AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_claim |-> bus_valid); // R1
    AST_RD_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_claim && !bus_write) |=> rd_valid); // R12
    AST_NO_RD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_claim && bus_write) |=> !rd_valid); // R12
    AST_MASK_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_claim && bus_write) |=> !mask_evt); // R8
    AST_RESVC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_claim && bus_write) |=> !resvc_req); // R9
endmodule

bind irq_regwin irq_regwin_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_claim(bus_claim), .rd_valid(rd_valid), .mask_evt(mask_evt),
    .resvc_req(resvc_req)
);

// File: tb/irq_regwin_tb.sv
// Bench: directed corners plus seeded random traffic against a bench model.
module irq_regwin_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          NP   = 24;
    localparam logic [31:0] BASE = 32'hFEC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0]  bus_len = '0;
    logic [NP-1:0] pend_i = '0, rirr_set = '0;
    logic        bus_claim, rd_valid, mask_evt, mask_val, resvc_req;
    logic [31:0] rd_data;
    logic [4:0]  evt_index;

    int n_cmp = 0, n_bad = 0;

    logic [63:0] m_ent [NP];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_regwin dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_len(bus_len), .bus_wdata(bus_wdata),
        .bus_claim(bus_claim), .rd_valid(rd_valid), .rd_data(rd_data),
        .pend_i(pend_i), .rirr_set(rirr_set), .evt_index(evt_index),
        .mask_evt(mask_evt), .mask_val(mask_val), .resvc_req(resvc_req)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input logic [3:0] len, input logic [31:0] d);
        if (len == 1) return {24'd0, d[7:0]};
        if (len == 2) return {16'd0, d[15:0]};
        return d;
    endfunction

    function automatic logic [31:0] mdl_win();
        int ix = (int'(m_sel) - 16) >>> 1;
        if (m_sel >= 8'h10) begin
            if (ix < NP) return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
            return 32'hFFFF_FFFF;
        end
        if (m_sel == 0) return {4'd0, m_id, 24'd0};
        if (m_sel == 1) return 32'h0017_0011;
        return 0;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_sel = 0;
        m_id  = 0;
    endtask

    // One write cycle with optional remote-IRR pulses; checks claim and strobes.
    task automatic do_write(input logic [31:0] addr, input logic [3:0] len, input logic [31:0] d,
                            input logic [NP-1:0] pend, input logic [NP-1:0] rset);
        logic inr, lok, e_mask, e_resvc, nm, nt;
        int ix;
        logic [31:0] x;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = addr; bus_len = len; bus_wdata = d;
        pend_i = pend; rirr_set = rset;
        inr = addr[31:8] == BASE[31:8];
        lok = (len == 1) || (len == 2) || (len == 4) || (len == 8);
        x = ext(len, d);
        e_mask = 0; e_resvc = 0; nm = 0;
        ix = (int'(m_sel) - 16) >>> 1;
        #1 chk(bus_claim == inr, "R1 claim", bus_claim, inr);
        if (inr && lok) begin
            if (addr[7:0] == 8'h00) m_sel = x[7:0];
            else if (addr[7:0] == 8'h10) begin
                if (m_sel == 0) m_id = x[27:24];
                else if (m_sel >= 8'h10 && ix < NP) begin
                    nm = m_sel[0] ? m_ent[ix][16] : x[16];
                    nt = m_sel[0] ? m_ent[ix][15] : x[15];
                    e_mask  = nm != m_ent[ix][16];
                    e_resvc = nt && pend[ix];
                    if (m_sel[0]) m_ent[ix][63:32] = x;
                    else begin m_ent[ix][31:0] = x; m_ent[ix][14] = 0; end
                end
            end
        end
        for (int i = 0; i < NP; i++) if (rset[i]) m_ent[i][14] = 1'b1;
        @(negedge clk);
        bus_valid = 0; rirr_set = '0;
        chk(mask_evt == e_mask, "R8 mask_evt", mask_evt, e_mask);
        chk(resvc_req == e_resvc, "R9 resvc_req", resvc_req, e_resvc);
        chk(rd_valid == 1'b0, "R12 no rd on write", rd_valid, 0);
        if (e_mask) chk(mask_val == nm, "R8 mask_val", mask_val, nm);
        if (e_mask || e_resvc) chk(int'(evt_index) == ix, "R8 R9 evt_index", evt_index, ix);
    endtask

    task automatic do_read(input logic [31:0] addr, input string req);
        logic inr;
        logic [31:0] e;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = addr; bus_len = 4;
        inr = addr[31:8] == BASE[31:8];
        if (addr[7:0] == 8'h00) e = {24'd0, m_sel};
        else if (addr[7:0] == 8'h10) e = mdl_win();
        else e = 0;
        @(negedge clk);
        bus_valid = 0;
        chk(rd_valid == inr, {req, " R12 rd_valid"}, rd_valid, inr);
        if (inr) chk(rd_data == e, {req, " rd_data"}, rd_data, e);
    endtask

    task automatic wsel(input logic [7:0] s);
        do_write(BASE, 4, {24'd0, s}, '0, '0);
    endtask

    initial begin
        logic [31:0] r;
        mdl_reset();
        repeat (3) @(negedge clk);
        chk(rd_valid == 0 && mask_evt == 0 && resvc_req == 0, "R11 outputs", {rd_valid, mask_evt, resvc_req}, 0);
        rst_n = 1;
        // R11: reset values
        do_read(BASE, "R11 sel");
        do_read(BASE + 32'h10, "R11 id");
        wsel(8'h10); do_read(BASE + 32'h10, "R11 entry0 lo");
        wsel(8'h3F); do_read(BASE + 32'h10, "R11 entry23 hi");
        // R2: select truncated to 8 bits
        do_write(BASE, 8, 32'hABCD_1234, '0, '0);
        do_read(BASE, "R2 sel trunc");
        // R10: version, id, misc
        wsel(8'h01); do_read(BASE + 32'h10, "R10 version");
        wsel(8'h00); do_write(BASE + 32'h10, 4, 32'hFFFF_FFFF, '0, '0);
        do_read(BASE + 32'h10, "R10 id");
        wsel(8'h07); do_read(BASE + 32'h10, "R10 other");
        // R1: unclaimed and odd offsets
        do_read(32'hFEC1_0010, "R1 out of region");
        do_read(BASE + 32'h20, "R1 other offset");
        // R4: index 24 read all ones, write ignored
        wsel(8'h40); do_read(BASE + 32'h10, "R4 oob read");
        do_write(BASE + 32'h10, 4, 32'h0000_0000, '1, '0);
        wsel(8'h3E); do_read(BASE + 32'h10, "R4 entry23 untouched");
        // R7: bad length dropped, byte length zero-extended
        wsel(8'h12); do_write(BASE + 32'h10, 3, 32'h0000_8055, '1, '0);
        do_read(BASE + 32'h10, "R7 len3 dropped");
        do_write(BASE + 32'h10, 1, 32'hFFFF_8055, '1, '0);
        do_read(BASE + 32'h10, "R7 len1");
        // R9: level with pending, R5 upper write
        do_write(BASE + 32'h10, 2, 32'h0000_8021, 24'h2, '0);
        wsel(8'h13); do_write(BASE + 32'h10, 4, 32'h5A00_0000, 24'h2, '0);
        do_read(BASE + 32'h10, "R5 upper");
        // R6 vs R5 collision: lower write and set in same cycle
        wsel(8'h14); do_write(BASE + 32'h10, 4, 32'h0000_4000, '0, 24'h4);
        do_read(BASE + 32'h10, "R6 set wins");
        do_write(BASE + 32'h10, 4, 32'h0000_4000, '0, '0);
        do_read(BASE + 32'h10, "R5 rirr cleared");
        // Seeded random traffic
        void'($urandom(32'd12345));
        for (int k = 0; k < 1500; k++) begin
            int op = $urandom_range(0, 99);
            logic [3:0] ln;
            case ($urandom_range(0, 5))
                0: ln = 1; 1: ln = 2; 2: ln = 4; 3: ln = 8; 4: ln = 4; default: ln = 4'($urandom_range(0, 15));
            endcase
            if (op < 25) wsel(8'($urandom_range(0, 99) < 85 ? $urandom_range(16, 67) : $urandom_range(0, 255)));
            else if (op < 60) do_write(BASE + 32'h10, ln, $urandom, NP'($urandom),
                                       ($urandom_range(0, 3) == 0) ? NP'($urandom) : '0);
            else if (op < 90) do_read(BASE + 32'h10, "R3 R5 R6 random window");
            else if (op < 95) do_read(BASE, "R2 random sel");
            else do_write($urandom_range(0, 1) ? 32'hFEC0_0110 : BASE + 32'h30, ln, $urandom, '1, '0);
        end
        r = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule